// File: doc/BRIEF.md
# Twin Edge-Steered Up Counter

The block contains two identical 4-bit up counters, channels A and B. They share nothing except the system clock and the system reset. Each channel has two interchangeable count inputs. A step is taken on a rising edge of the clock-role input while the enable-role input is high. A step is also taken on a falling edge of the enable-role input while the clock-role input is low. Because of the second path, a channel can be chained to the next one by external wiring: the top bit of the lower channel drives the enable input of the upper channel, and the upper channel's clock input is tied low.

A build-time parameter sets the modulus. In decade mode a channel counts 0 to 9 and then wraps; in binary mode it counts 0 to 15 and then wraps. All logic runs on one fast system clock. The slow count inputs pass through a two-flop synchronizer, and edges are found by comparing each sample with the one before it. The per-channel clear is level-sensitive: asserting it forces the count to zero at once, and its release is aligned to the system clock.

Top module: `dual_edge_counter`

## Requirements
- R1: The two channels are independent: stimulus on one channel's inputs never changes the other channel's count. Count bit 0 is the least significant bit.
- R2: While a channel's enable input is high, each rising edge of its clock input increments the count by exactly one.
- R3: While a channel's clock input is low, each falling edge of its enable input increments the count by exactly one.
- R4: While a channel's clear input is high, its count reads 0 without waiting for a system clock edge, and count edges are ignored. After the clear is released, counting resumes from 0.
- R5: With DECADE=1 the count runs 0..9 and then returns to 0. With DECADE=0 it runs 0..15 and then returns to 0. A decade-mode count never exceeds 9.
- R6: Every change of a count is either +1 or a wrap to 0 (or a clear). Each qualifying edge gives exactly one increment.
- R7: No increment occurs for a rising clock while enable is low, for a falling enable while clock is high, or for a rising clock and a falling enable seen in the same system cycle. If both inputs stay steady, the count stays steady.
- R8: When channel A's top count bit drives channel B's enable and B's clock is held low, B advances exactly once per full cycle of A, at A's wrap to 0.
- R9: A qualifying input edge that is set up before system clock edge k shows on the count output just after system clock edge k+2. The count still holds its old value after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | System reset, active low, asynchronous |
| a_clk_in | input | 1 | Channel A clock-role count input |
| a_en_in | input | 1 | Channel A enable-role count input |
| a_clr_in | input | 1 | Channel A clear, active high |
| a_q | output | 4 | Channel A count |
| b_clk_in | input | 1 | Channel B clock-role count input |
| b_en_in | input | 1 | Channel B enable-role count input |
| b_clr_in | input | 1 | Channel B clear, active high |
| b_q | output | 4 | Channel B count |

## Verification
Two detection paths can fire in the same system cycle: a rising clock-role input and a falling enable-role input. The bench provokes this by switching both inputs at the same falling edge of the system clock, so that both changes reach the synchronizer together. The expected result is that the count does not move, because each path's gate reads the other input's new level. A second clash is a count edge arriving while the clear is asserted. Here the clear must win and the count must stay at 0, and this is judged at the ports both during the clear and after its release.

// File: rtl/dual_edge_counter_pkg.sv
package dual_edge_counter_pkg;
  localparam int unsigned CH_COUNT = 2;

  typedef struct packed {
    logic en;
    logic ck;
  } cnt_pins_t;

  function automatic logic [3:0] bump4(input logic [3:0] cur, input logic [3:0] last);
    return (cur == last) ? 4'd0 : cur + 4'd1;
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe[s] <= '0;
        else         pipe[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe[s] <= '0;
        else         pipe[s] <= pipe[s-1];
      end
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/edge_qualify.sv
module edge_qualify (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  dual_edge_counter_pkg::cnt_pins_t now_i,
  output logic                             step_o
);
  dual_edge_counter_pkg::cnt_pins_t prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev <= '0;
    else         prev <= now_i;
  end

  logic ck_rise, en_fall;
  assign ck_rise = now_i.ck & ~prev.ck;
  assign en_fall = prev.en & ~now_i.en;

  // each path is gated by the other input's present level
  assign step_o = (ck_rise & now_i.en) | (en_fall & ~now_i.ck);
endmodule

// File: rtl/clear_align.sv
module clear_align #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic hold_o
);
  logic arst;
  logic [STAGES-1:0] sh;

  assign arst = clr_i | ~rst_ni;

  always_ff @(posedge clk_i or posedge arst) begin
    if (arst) sh <= '1;
    else      sh <= {sh[STAGES-2:0], 1'b0};
  end

  assign hold_o = sh[STAGES-1];
endmodule

// File: rtl/count_core.sv
module count_core #(
  parameter int unsigned W      = 4,
  parameter bit          DECADE = 1'b1
) (
  input  logic         clk_i,
  input  logic         hold_i,
  input  logic         step_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] LAST = DECADE ? W'(9) : {W{1'b1}};

  logic [W-1:0] nxt;

  if (W == 4) begin : g_w4
    assign nxt = dual_edge_counter_pkg::bump4(q_o, LAST);
  end else begin : g_wn
    assign nxt = (q_o == LAST) ? '0 : q_o + W'(1);
  end

  always_ff @(posedge clk_i or posedge hold_i) begin
    if (hold_i)      q_o <= '0;
    else if (step_i) q_o <= nxt;
  end
endmodule

// File: rtl/dual_edge_counter.sv
module dual_edge_counter #(
  parameter int unsigned CNT_W     = 4,
  parameter bit          DECADE    = 1'b1,
  parameter int unsigned SYNC_LEN  = 2,
  parameter int unsigned CLR_STAGE = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a_clk_in,
  input  logic             a_en_in,
  input  logic             a_clr_in,
  output logic [CNT_W-1:0] a_q,
  input  logic             b_clk_in,
  input  logic             b_en_in,
  input  logic             b_clr_in,
  output logic [CNT_W-1:0] b_q
);
  import dual_edge_counter_pkg::*;

  localparam int unsigned NCH = CH_COUNT;

  cnt_pins_t        raw   [NCH];
  logic [NCH-1:0]   clr;
  logic [CNT_W-1:0] cnt   [NCH];

  assign raw[0] = '{en: a_en_in, ck: a_clk_in};
  assign raw[1] = '{en: b_en_in, ck: b_clk_in};
  assign clr    = {b_clr_in, a_clr_in};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    cnt_pins_t smp;
    logic      step;
    logic      hold;

    pin_sync #(.W($bits(cnt_pins_t)), .STAGES(SYNC_LEN)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw[ch]),
      .q_o   (smp)
    );

    edge_qualify u_edge (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .now_i (smp),
      .step_o(step)
    );

    clear_align #(.STAGES(CLR_STAGE)) u_clr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (clr[ch]),
      .hold_o(hold)
    );

    count_core #(.W(CNT_W), .DECADE(DECADE)) u_cnt (
      .clk_i (clk_i),
      .hold_i(hold),
      .step_i(step),
      .q_o   (cnt[ch])
    );
  end

  assign a_q = cnt[0];
  assign b_q = cnt[1];
endmodule

// File: rtl/dual_edge_counter_chk.sv
module dual_edge_counter_chk #(
  parameter int unsigned CNT_W  = 4,
  parameter bit          DECADE = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             a_clk_in,
  input logic             a_en_in,
  input logic             a_clr_in,
  input logic [CNT_W-1:0] a_q,
  input logic             b_clk_in,
  input logic             b_en_in,
  input logic             b_clr_in,
  input logic [CNT_W-1:0] b_q
);
  // R4: an asserted clear holds the count at zero
  a_r4_a_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_clr_in |-> (a_q == '0));
  a_r4_b_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_clr_in |-> (b_q == '0));

  // R5: decade mode stays within 0..9
  a_r5_a_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    DECADE |-> (a_q <= CNT_W'(9)));
  a_r5_b_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    DECADE |-> (b_q <= CNT_W'(9)));

  // R6: a count moves by +1 or to zero
  a_r6_a_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_q != $past(a_q)) |-> ((a_q == $past(a_q) + CNT_W'(1)) || (a_q == '0)));
  a_r6_b_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_q != $past(b_q)) |-> ((b_q == $past(b_q) + CNT_W'(1)) || (b_q == '0)));

  // R7: steady inputs keep the count steady
  a_r7_a_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(a_clk_in) && $past($stable(a_clk_in)) && $past($stable(a_clk_in), 2) &&
     $stable(a_en_in) && $past($stable(a_en_in)) && $past($stable(a_en_in), 2) && !a_clr_in)
    |=> ($stable(a_q) || a_clr_in));
  a_r7_b_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(b_clk_in) && $past($stable(b_clk_in)) && $past($stable(b_clk_in), 2) &&
     $stable(b_en_in) && $past($stable(b_en_in)) && $past($stable(b_en_in), 2) && !b_clr_in)
    |=> ($stable(b_q) || b_clr_in));
endmodule

bind dual_edge_counter dual_edge_counter_chk #(.CNT_W(CNT_W), .DECADE(DECADE)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .a_clk_in(a_clk_in),
  .a_en_in (a_en_in),
  .a_clr_in(a_clr_in),
  .a_q     (a_q),
  .b_clk_in(b_clk_in),
  .b_en_in (b_en_in),
  .b_clr_in(b_clr_in),
  .b_q     (b_q)
);

// File: tb/sim_dual_edge_counter.sv
module sim_dual_edge_counter;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_ck = 1'b0, a_en = 1'b0, a_clr = 1'b0;
  logic b_ck = 1'b0, b_en_drv = 1'b0, b_clr = 1'b0;
  logic cascade = 1'b0;
  logic b_en;
  logic [3:0] a_q, b_q, bin_a_q, bin_b_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(PERIOD / 2) clk = ~clk;

  assign b_en = cascade ? a_q[3] : b_en_drv;

  dual_edge_counter #(.DECADE(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .a_clk_in(a_ck), .a_en_in(a_en), .a_clr_in(a_clr), .a_q(a_q),
    .b_clk_in(b_ck), .b_en_in(b_en), .b_clr_in(b_clr), .b_q(b_q)
  );

  dual_edge_counter #(.DECADE(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n),
    .a_clk_in(a_ck), .a_en_in(a_en), .a_clr_in(a_clr), .a_q(bin_a_q),
    .b_clk_in(b_ck), .b_en_in(b_en), .b_clr_in(b_clr), .b_q(bin_b_q)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  task automatic settle(input int n = 4);
    repeat (n) @(negedge clk);
  endtask

  task automatic a_pins(input logic ck, input logic en);
    a_ck = ck; a_en = en; settle();
  endtask

  task automatic a_rise_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      a_pins(1'b1, 1'b1);
      a_pins(1'b0, 1'b1);
    end
  endtask

  task automatic clear_all();
    a_clr = 1'b1; b_clr = 1'b1; settle();
    a_clr = 1'b0; b_clr = 1'b0; settle();
  endtask

  task automatic t_reset();
    chk("R1 reset a", a_q, 4'd0);
    chk("R1 reset b", b_q, 4'd0);
  endtask

  task automatic t_clock_edge();
    a_pins(1'b0, 1'b1);
    a_rise_pulses(3);
    chk("R2 three rises", a_q, 4'd3);
    chk("R1 b untouched", b_q, 4'd0);
  endtask

  task automatic t_enable_edge();
    clear_all();
    a_pins(1'b0, 1'b1);
    a_pins(1'b0, 1'b0);
    chk("R3 one fall", a_q, 4'd1);
    a_pins(1'b0, 1'b1);
    chk("R3 enable rise no step", a_q, 4'd1);
    a_pins(1'b0, 1'b0);
    chk("R3 two falls", a_q, 4'd2);
    chk("R1 b untouched", b_q, 4'd0);
  endtask

  task automatic t_blocked();
    a_pins(1'b0, 1'b0);
    a_pins(1'b1, 1'b0);
    chk("R7 rise with enable low", a_q, 4'd2);
    a_pins(1'b1, 1'b1);
    a_pins(1'b1, 1'b0);
    chk("R7 fall with clock high", a_q, 4'd2);
    a_pins(1'b0, 1'b1);
    a_pins(1'b1, 1'b0);
    chk("R7 simultaneous rise and fall", a_q, 4'd2);
    settle(6);
    chk("R7 steady inputs", a_q, 4'd2);
  endtask

  task automatic t_latency();
    clear_all();
    a_pins(1'b0, 1'b1);
    a_ck = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R9 old after two edges", a_q, 4'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R9 new after third edge", a_q, 4'd1);
    a_pins(1'b0, 1'b1);
  endtask

  task automatic t_wrap_decade();
    clear_all();
    a_pins(1'b0, 1'b1);
    for (int v = 1; v <= 9; v++) begin
      a_rise_pulses(1);
      chk("R6 decade step", a_q, 4'(v));
    end
    a_rise_pulses(1);
    chk("R5 decade wrap to 0", a_q, 4'd0);
    chk("R5 binary same pulses", bin_a_q, 4'd10);
  endtask

  task automatic t_wrap_binary();
    clear_all();
    a_pins(1'b0, 1'b1);
    a_rise_pulses(15);
    chk("R5 binary at 15", bin_a_q, 4'd15);
    chk("R5 decade at 5", a_q, 4'd5);
    a_rise_pulses(1);
    chk("R5 binary wrap to 0", bin_a_q, 4'd0);
  endtask

  task automatic t_clear();
    clear_all();
    a_pins(1'b0, 1'b1);
    a_rise_pulses(4);
    b_ck = 1'b0; b_en_drv = 1'b1; settle();
    b_ck = 1'b1; settle(); b_ck = 1'b0; settle();
    chk("R1 b counts alone", b_q, 4'd1);
    @(negedge clk);
    a_clr = 1'b1;
    #1;
    chk("R4 immediate zero", a_q, 4'd0);
    a_rise_pulses(2);
    chk("R4 edges ignored in clear", a_q, 4'd0);
    chk("R1 b kept during a clear", b_q, 4'd1);
    a_clr = 1'b0; settle();
    chk("R4 zero after release", a_q, 4'd0);
    a_rise_pulses(1);
    chk("R4 resumes from 0", a_q, 4'd1);
    b_en_drv = 1'b0; settle();
  endtask

  task automatic t_cascade();
    b_ck = 1'b0; b_en_drv = 1'b0; settle();
    cascade = 1'b1; settle();
    clear_all();
    a_pins(1'b0, 1'b1);
    a_rise_pulses(9);
    chk("R8 b idle before wrap", b_q, 4'd0);
    a_rise_pulses(1);
    chk("R8 a wrapped", a_q, 4'd0);
    chk("R8 b after one cycle", b_q, 4'd1);
    a_rise_pulses(10);
    chk("R8 b after two cycles", b_q, 4'd2);
    cascade = 1'b0; settle();
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle();
    t_reset();
    t_clock_edge();
    t_enable_edge();
    t_blocked();
    t_latency();
    t_wrap_decade();
    t_wrap_binary();
    t_clear();
    t_cascade();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule